// File: doc/BRIEF.md
# Serial fuse programming timing engine

This engine sits between a fuse controller's register front-end and the fuse array. It takes one request at a time. A write request carries a word address, a 32-bit program value and the current contents of the timing register. The engine first senses the addressed word and clears from the program value every bit that is already blown. It then walks the word from bit 0 to bit 31 and fires one program strobe for each remaining 1 bit, shifting its data copy right with zero fill as it goes. A reload request senses every word of the array in address order and pushes each result to the shadow copies.

Every pulse width comes from the timing fields, which are captured when the request is accepted. The program strobe and read strobe widths come from their own fields. Every setup and hold phase around a strobe lasts the relax count plus one cycle. After a write finishes, a fixed postamble keeps the engine from taking the next request. Requests use a valid/ready handshake. The requester holds `req_valid` and the whole payload steady until it sees `req_ready` high at a clock edge. A request offered while `req_ready` is low has no effect. The shadow output has no back-pressure: the receiver must take each `shadow_we` pulse in the cycle it occurs.

Top module: `fuse_prog_engine`

## Requirements
- R1: The timing input packs the program strobe width in bits 11:0, the relax count in bits 15:12 and the read strobe width in bits 21:16. The engine captures it on the accepting edge, so later changes do not affect an operation in flight.
- R2: `req_ready` is high only while the engine is idle and no postamble is pending. A request is taken at an edge where `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle. A request offered while `req_ready` is low changes nothing.
- R3: A write opens with a sense of the addressed word: relax+1 setup cycles, the read strobe, then relax+1 hold cycles. Bits that read back as 1 are removed from the program data, so no fuse bit is ever strobed twice.
- R4: Bits are handled in order from 0 to 31, with one evaluation cycle per bit. A set bit then gets relax+1 setup cycles, a program strobe with `fuse_bit` equal to its index, and relax+1 hold cycles. A clear bit gets no strobe.
- R5: The program strobe lasts exactly the programmed width and the read strobe exactly its width. A width field of 0 gives a one-cycle strobe.
- R6: `done` is a one-cycle pulse in the cycle after the last phase. `busy` is low in that cycle.
- R7: After the `done` pulse of a write, `req_ready` stays low for `POST_CYCLES` cycles before it rises.
- R8: A reload senses words 0 up to the last address, each with the setup, read strobe and hold sequence. On the last cycle of each read strobe, `shadow_we` pulses with the word's address and sensed value. `reload_busy` stays high until the last word has been read. No postamble follows a reload.
- R9: The program strobe and read strobe are never high together, and `fuse_addr` and `fuse_bit` stay steady while a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_reload | input | 1 | 1 = reload all words, 0 = write one word |
| req_addr | input | ADDR_W | Word address for a write |
| req_data | input | DATA_W | Program value for a write |
| timing_cfg | input | 22 | Packed timing fields |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reload_busy | output | 1 | Reload in progress |
| fuse_addr | output | ADDR_W | Word select to the fuse array |
| fuse_bit | output | $clog2(DATA_W) | Bit index during programming |
| prog_strobe | output | 1 | Program strobe |
| read_strobe | output | 1 | Read (sense) strobe |
| fuse_rdata | input | DATA_W | Sensed word, valid while the read strobe is high |
| shadow_we | output | 1 | Shadow copy write pulse |
| shadow_addr | output | ADDR_W | Shadow word address |
| shadow_data | output | DATA_W | Shadow word value |

## Verification
The bench targets a second write to a word that already has blown bits. An engine that skipped the pre-read mask would strobe those bits again, and the extra program pulses would show up as cycle mismatches. It also uses zero width and zero relax fields, bit 31 as the only high bit with bit 0, and an all-zero write. An off-by-one in the phase counters or in the last-bit test would stretch or clip strobes, or end the operation one bit early. It offers requests while the engine is busy and during the postamble, and changes the timing input in mid-operation. An engine that took those requests, or that read the timing live, would drift from the model cycle by cycle. Finally, a reload over preloaded words checks the order, address and data of every shadow pulse.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int TIM_W = 22;
  localparam int CNT_W = 12;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RSET, ST_RSTB, ST_RHOLD, ST_BIT,
    ST_PSET, ST_PSTB, ST_PHOLD, ST_DONE
  } fpe_state_e;

  // read width at the top, relax in the middle, program width at the bottom
  typedef struct packed {
    logic [5:0]  rd_w;
    logic [3:0]  relax;
    logic [11:0] pg_w;
  } fpe_timing_t;

  function automatic logic [CNT_W-1:0] pad_len(input logic [3:0] relax);
    return CNT_W'(relax) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] strobe_len(input logic [CNT_W-1:0] w);
    return (w == '0) ? CNT_W'(1) : w;
  endfunction
endpackage

// File: rtl/fpe_phase_timer.sv
module fpe_phase_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/fpe_bit_shifter.sv
module fpe_bit_shifter #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          clr_en,
  input  logic [W-1:0]  clr_mask,
  input  logic          shift,
  output logic          lsb,
  output logic          at_last,
  output logic [IW-1:0] idx
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      idx    <= '0;
    end else if (load) begin
      data_q <= load_val;
      idx    <= '0;
    end else if (clr_en) begin
      data_q <= data_q & ~clr_mask;
    end else if (shift) begin
      data_q <= {1'b0, data_q[W-1:1]};
      idx    <= idx + IW'(1);
    end
  end

  assign lsb     = data_q[0];
  assign at_last = (idx == IW'(W-1));
endmodule

// File: rtl/fuse_prog_engine.sv
module fuse_prog_engine
  import fpe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int POST_CYCLES = 500
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_reload,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_data,
  input  logic [TIM_W-1:0]          timing_cfg,
  output logic                      busy,
  output logic                      done,
  output logic                      reload_busy,
  output logic [ADDR_W-1:0]         fuse_addr,
  output logic [$clog2(DATA_W)-1:0] fuse_bit,
  output logic                      prog_strobe,
  output logic                      read_strobe,
  input  logic [DATA_W-1:0]         fuse_rdata,
  output logic                      shadow_we,
  output logic [ADDR_W-1:0]         shadow_addr,
  output logic [DATA_W-1:0]         shadow_data
);
  localparam int POST_W = $clog2(POST_CYCLES + 1);

  fpe_state_e          state_q, state_d;
  logic                op_reload_q;
  logic [ADDR_W-1:0]   addr_q;
  fpe_timing_t         tim_q, tim_in;
  logic [POST_W-1:0]   post_q;

  logic                accept, tmr_load, tmr_last, addr_inc;
  logic [CNT_W-1:0]    tmr_val, relax_len, rd_len, pg_len;
  logic                sh_lsb, sh_last, sh_shift, sh_mask;

  assign tim_in    = fpe_timing_t'(timing_cfg);
  assign req_ready = (state_q == ST_IDLE) && (post_q == '0);
  assign accept    = req_valid && req_ready;

  assign relax_len = pad_len(tim_q.relax);
  assign rd_len    = strobe_len(CNT_W'(tim_q.rd_w));
  assign pg_len    = strobe_len(tim_q.pg_w);

  fpe_phase_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  fpe_bit_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(req_data),
    .clr_en(sh_mask), .clr_mask(fuse_rdata),
    .shift(sh_shift),
    .lsb(sh_lsb), .at_last(sh_last), .idx(fuse_bit)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_shift = 1'b0;
    sh_mask  = 1'b0;
    addr_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_RSET; tmr_load = 1'b1; tmr_val = pad_len(tim_in.relax);
      end
      ST_RSET: if (tmr_last) begin
        state_d = ST_RSTB; tmr_load = 1'b1; tmr_val = rd_len;
      end
      ST_RSTB: if (tmr_last) begin
        state_d = ST_RHOLD; tmr_load = 1'b1; tmr_val = relax_len;
        sh_mask = !op_reload_q;
      end
      ST_RHOLD: if (tmr_last) begin
        if (!op_reload_q)          state_d = ST_BIT;
        else if (addr_q == '1)     state_d = ST_DONE;
        else begin
          state_d = ST_RSET; addr_inc = 1'b1;
          tmr_load = 1'b1; tmr_val = relax_len;
        end
      end
      ST_BIT: begin
        if (sh_lsb) begin
          state_d = ST_PSET; tmr_load = 1'b1; tmr_val = relax_len;
        end else if (sh_last) state_d = ST_DONE;
        else sh_shift = 1'b1;
      end
      ST_PSET: if (tmr_last) begin
        state_d = ST_PSTB; tmr_load = 1'b1; tmr_val = pg_len;
      end
      ST_PSTB: if (tmr_last) begin
        state_d = ST_PHOLD; tmr_load = 1'b1; tmr_val = relax_len;
      end
      ST_PHOLD: if (tmr_last) begin
        if (sh_last) state_d = ST_DONE;
        else begin
          state_d = ST_BIT; sh_shift = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_reload_q <= 1'b0;
      addr_q      <= '0;
      tim_q       <= '0;
      post_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_reload_q <= req_reload;
        addr_q      <= req_reload ? '0 : req_addr;
        tim_q       <= tim_in;
      end else if (addr_inc) begin
        addr_q <= addr_q + ADDR_W'(1);
      end
      if (state_q == ST_DONE)
        post_q <= op_reload_q ? '0 : POST_W'(POST_CYCLES);
      else if (state_q == ST_IDLE && post_q != '0)
        post_q <= post_q - POST_W'(1);
    end
  end

  assign busy        = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done        = (state_q == ST_DONE);
  assign reload_busy = busy && op_reload_q;
  assign fuse_addr   = addr_q;
  assign prog_strobe = (state_q == ST_PSTB);
  assign read_strobe = (state_q == ST_RSTB);
  assign shadow_we   = read_strobe && tmr_last && op_reload_q;
  assign shadow_addr = addr_q;
  assign shadow_data = fuse_rdata;
endmodule

// File: rtl/fuse_prog_engine_chk.sv
module fuse_prog_engine_chk #(
  parameter int ADDR_W = 6,
  parameter int BIT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              reload_busy,
  input logic              prog_strobe,
  input logic              read_strobe,
  input logic [ADDR_W-1:0] fuse_addr,
  input logic [BIT_W-1:0]  fuse_bit,
  input logic              shadow_we
);
  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_strobe && read_strobe));

  a_r9_select_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_strobe && $past(prog_strobe)) || (read_strobe && $past(read_strobe)))
      |-> ($stable(fuse_addr) && $stable(fuse_bit)));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r2_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_shadow_in_reload: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |-> (reload_busy && read_strobe));
endmodule

bind fuse_prog_engine fuse_prog_engine_chk #(
  .ADDR_W(ADDR_W),
  .BIT_W ($clog2(DATA_W))
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .reload_busy(reload_busy),
  .prog_strobe(prog_strobe), .read_strobe(read_strobe),
  .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .shadow_we(shadow_we)
);

// File: tb/fuse_prog_engine_bench.sv
`timescale 1ns/1ps
module fuse_prog_engine_bench;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int DEPTH = 1 << AW;
  localparam int POST  = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_reload = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [21:0]   timing_cfg = '0;
  logic          req_ready, busy, done, reload_busy, prog_strobe, read_strobe, shadow_we;
  logic [AW-1:0] fuse_addr, shadow_addr;
  logic [4:0]    fuse_bit;
  logic [DW-1:0] fuse_rdata, shadow_data;

  fuse_prog_engine #(.ADDR_W(AW), .DATA_W(DW), .POST_CYCLES(POST)) u_fuse_prog_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_reload(req_reload), .req_addr(req_addr), .req_data(req_data),
    .timing_cfg(timing_cfg), .busy(busy), .done(done), .reload_busy(reload_busy),
    .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .prog_strobe(prog_strobe),
    .read_strobe(read_strobe), .fuse_rdata(fuse_rdata), .shadow_we(shadow_we),
    .shadow_addr(shadow_addr), .shadow_data(shadow_data)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] preload(input int w);
    return (w >= 40) ? (32'h1234_5678 ^ (w * 32'h0101_0101)) : '0;
  endfunction

  // behavioural fuse array driven by the engine's outputs
  logic [DW-1:0] env_mem [DEPTH];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) env_mem[w] <= preload(w);
    end else if (prog_strobe) begin
      env_mem[fuse_addr][fuse_bit] <= 1'b1;
    end
  end
  assign fuse_rdata = read_strobe ? env_mem[fuse_addr] : '0;

  // reference model
  logic [DW-1:0] exp_mem [DEPTH];
  bit e_ready = 1'b0, e_busy = 1'b0, e_done = 1'b0, e_rb = 1'b0;
  bit e_prog = 1'b0, e_read = 1'b0, e_swe = 1'b0, model_on = 1'b0;
  int e_addr = 0, e_bit = 0;
  logic [DW-1:0] e_sdata = '0;

  task automatic tick();
    @(posedge clk); #0.5;
  endtask

  task automatic hold(input int n);
    repeat (n) tick();
  endtask

  task automatic sense(input int w, input int rlx, input int rdw, input bit rl,
                       output logic [DW-1:0] val);
    e_addr = w;
    hold(rlx);
    e_read = 1'b1;
    val = exp_mem[w];
    for (int i = 0; i < rdw; i++) begin
      e_swe   = rl && (i == rdw - 1);
      e_sdata = exp_mem[w];
      tick();
    end
    e_read = 1'b0;
    e_swe  = 1'b0;
    hold(rlx);
  endtask

  task automatic run_op();
    bit rl;
    int a, rlx, rdw, pgw;
    logic [DW-1:0] d, sensed, m;
    logic [21:0] t;
    rl = req_reload; a = req_addr; d = req_data; t = timing_cfg;
    rlx = int'(t[15:12]) + 1;
    rdw = (t[21:16] == 0) ? 1 : int'(t[21:16]);
    pgw = (t[11:0] == 0) ? 1 : int'(t[11:0]);
    e_ready = 1'b0; e_busy = 1'b1; e_rb = rl;
    if (rl) begin
      for (int w = 0; w < DEPTH; w++) sense(w, rlx, rdw, 1'b1, sensed);
    end else begin
      sense(a, rlx, rdw, 1'b0, sensed);
      m = d & ~sensed;
      for (int b = 0; b < DW; b++) begin
        e_bit = b;
        tick();
        if (m[b]) begin
          hold(rlx);
          e_prog = 1'b1;
          hold(pgw);
          e_prog = 1'b0;
          exp_mem[a][b] = 1'b1;
          hold(rlx);
        end
      end
    end
    e_busy = 1'b0; e_rb = 1'b0; e_done = 1'b1;
    tick();
    e_done = 1'b0;
    if (!rl) hold(POST);
    e_ready = 1'b1;
  endtask

  initial begin : ref_model
    for (int w = 0; w < DEPTH; w++) exp_mem[w] = preload(w);
    @(posedge rst_n);
    e_ready  = 1'b1;
    model_on = 1'b1;
    forever begin
      tick();
      if (req_valid && e_ready) run_op();
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!busy && !done && !prog_strobe && !read_strobe && !shadow_we && !reload_busy,
          "R2", "reset state", {busy, done, prog_strobe, read_strobe, shadow_we}, 0);
    end else if (model_on) begin
      chk(req_ready == e_ready, "R2 R7", "req_ready", req_ready, e_ready);
      chk(busy == e_busy, "R2", "busy", busy, e_busy);
      chk(done == e_done, "R6", "done", done, e_done);
      chk(reload_busy == e_rb, "R8", "reload_busy", reload_busy, e_rb);
      chk(read_strobe == e_read, "R3 R5", "read_strobe", read_strobe, e_read);
      chk(prog_strobe == e_prog, "R4 R5", "prog_strobe", prog_strobe, e_prog);
      chk(shadow_we == e_swe, "R8", "shadow_we", shadow_we, e_swe);
      if (e_prog || e_read)
        chk(fuse_addr == AW'(e_addr), "R9", "fuse_addr", fuse_addr, e_addr);
      if (e_prog)
        chk(fuse_bit == 5'(e_bit), "R4", "fuse_bit", fuse_bit, e_bit);
      if (e_swe)
        chk(shadow_addr == AW'(e_addr) && shadow_data == e_sdata, "R8", "shadow word",
            shadow_data, e_sdata);
    end
  end

  function automatic logic [21:0] tim(input int pg, input int rx, input int rd);
    return {6'(rd), 4'(rx), 12'(pg)};
  endfunction

  task automatic send(input bit rl, input int a, input logic [DW-1:0] d, input logic [21:0] t);
    @(negedge clk);
    req_reload = rl; req_addr = AW'(a); req_data = d; timing_cfg = t; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic poke(input int n);
    req_valid = 1'b1; req_data = 32'hDEAD_BEEF; req_addr = AW'(3);
    repeat (n) @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : stimulus
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R3 R4: fresh word, several set bits
    send(1'b0, 5, 32'h0000_00A5, tim(5, 1, 3));
    wait_done();
    // R3: bits 0,2 already blown are masked; R1 timing change and R2 poke mid-flight
    send(1'b0, 5, 32'h0000_0F0F, tim(5, 1, 3));
    repeat (3) @(negedge clk);
    timing_cfg = tim(40, 9, 20);
    poke(3);
    wait_done();
    // R5: zero widths and zero relax; R4 bit 31 edge
    send(1'b0, 6, 32'h8000_0001, tim(0, 0, 0));
    wait_done();
    // R4: no bits to burn; R7 poke inside the postamble
    send(1'b0, 7, 32'h0000_0000, tim(3, 2, 2));
    wait_done();
    @(negedge clk);
    poke(3);
    // R3: word with preloaded pattern, program all ones
    send(1'b0, 41, 32'hFFFF_FFFF, tim(2, 2, 5));
    wait_done();
    // R8: reload of every word
    send(1'b1, 0, 32'h0, tim(7, 1, 2));
    wait_done();
    repeat (10) @(negedge clk);
    // R3 R4: final array content
    for (int w = 0; w < DEPTH; w++)
      chk(env_mem[w] == exp_mem[w], "R3", "fuse word", env_mem[w], exp_mem[w]);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule